// File: doc/BRIEF.md
# Multi-Standard Composite Sync Generator

This block produces composite sync, composite blanking and vertical drive for seven broadcast television standards. It advances on a pixel-rate tick enable. Every scan line lasts 320 ticks. A three-bit selector picks the standard. A one-bit mode input chooses between the interlaced 625/525-line frame and a non-interlaced 624/524-line frame, in which both fields are the same. The block also reports its horizontal position, the current line number and the field index, so that downstream logic can place further pulses such as burst key, clamp or identification.

Vertical position is held as a half-line index that runs over the whole frame. A field starts at half-line 0 or at half-line L, where L is the number of lines in the frame. When L is odd, the second field therefore starts in the middle of a line, and that is how interlace arises. A synchronous frame-reset input puts the scan back at the start of line 1 of the first field. Output pulses are active high.

Top module: `mstd_sync_gen`

## Requirements
- R1: `h_pos` counts 0 to 319 and then wraps to 0. It advances only on cycles where `tick` is high. When `tick` is low, no counter and no output changes.
- R2: `line_no` equals (half-line index / 2) + 1. The frame has 625 lines for codes 000, 001, 100, 101 and 111, and 525 lines for codes 010, 011 and 110. When `single_field` is 1, one line is removed from the frame.
- R3: `field_idx` is 1 from half-line L to the end of the frame and 0 before half-line L. With 625 or 525 lines, the second field therefore begins at tick 160 of line 313 or line 263.
- R4: Outside the vertical interval, `csync` is high for ticks 0 to 23 of each line.
- R5: The vertical interval opens each field with E half-lines of equalizing pulses and closes with another E half-lines. E is 5 for 625-line codes and 6 for 525-line codes. During these half-lines, `csync` is high for the first 12 ticks of each half-line.
- R6: Between the two equalizing groups there are S half-lines of broad pulses. S is 7 for code 011, 6 for the other 525-line codes and 5 for 625-line codes. During these half-lines, `csync` is high except for the last 24 ticks of each 160-tick half-line.
- R7: Horizontal blanking starts 8 ticks before the line start (tick 312) and lasts W ticks. W is 56 for code 010, 53 for code 110 and 60 for all other codes.
- R8: `cblank` is also high for the first 2·V half-lines of each field. V is 21 for code 010, 19 for code 110 and 25 for all other codes.
- R9: `vdrive` is high for the first 10 lines (625-line codes) or the first 6 lines (525-line codes) of each field, delayed by 8 ticks.
- R10: A tick with `frame_rst` high sets `h_pos` to 0, `line_no` to 1 and `field_idx` to 0.
- R11: After reset, `csync`, `cblank` and `vdrive` are 0, `h_pos` is 0, `line_no` is 1 and `field_idx` is 0.

`csync`, `cblank` and `vdrive` are registered. On each tick they take the value that belongs to the position held before that tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Pixel-rate enable |
| frame_rst | input | 1 | Return to line 1 of field 1 on the next tick |
| std_sel | input | 3 | Television standard code |
| single_field | input | 1 | 1 selects the non-interlaced 624/524-line frame |
| csync | output | 1 | Composite sync, active high |
| cblank | output | 1 | Composite blanking, active high |
| vdrive | output | 1 | Vertical drive, active high |
| h_pos | output | 9 | Tick position within the line |
| line_no | output | 10 | Current line, counted from 1 |
| field_idx | output | 1 | 0 for the first field, 1 for the second |

## Verification
A horizontal counter that slips shows up at once: `h_pos` is wrong, and within one line the sync edge moves against the blanking edge. A half-line index that is wrong shows within one tick on `line_no`. It reaches the pulse outputs only when the scan enters a vertical interval, where the equalizing and broad pulse counts come out wrong. A field boundary that is placed wrongly is visible only near half-line L, where `field_idx`, the second vertical interval and the vertical drive all move together. For this reason the stimulus runs through the second field of an interlaced 525-line frame and also through the line-aligned boundary of a 624-line frame.

// File: rtl/mstd_sync_pkg.sv
package mstd_sync_pkg;

    localparam int LINE_TICKS = 320;
    localparam int MAX_LINES  = 625;
    localparam int HCW        = $clog2(LINE_TICKS);
    localparam int LNW        = $clog2(MAX_LINES + 1);
    localparam int HLW        = LNW + 1;

    localparam logic [HCW-1:0] H_LAST      = HCW'(LINE_TICKS - 1);
    localparam logic [HCW-1:0] H_HALF      = HCW'(LINE_TICKS / 2);
    localparam logic [HCW-1:0] H_HALF_LAST = HCW'(LINE_TICKS / 2 - 1);
    localparam logic [HCW-1:0] SYNC_TICKS  = HCW'(24);
    localparam logic [HCW-1:0] EQ_TICKS    = HCW'(12);
    localparam logic [HCW-1:0] SERR_GAP    = HCW'(24);
    localparam logic [HCW-1:0] PORCH_TICKS = HCW'(8);
    localparam logic [HCW-1:0] VD_LAG      = HCW'(8);

    typedef enum logic [2:0] {
        STD_SECAM_A = 3'd0,
        STD_PAL_N   = 3'd1,
        STD_NTSC_A  = 3'd2,
        STD_PAL_M   = 3'd3,
        STD_SECAM_B = 3'd4,
        STD_PAL_BG  = 3'd5,
        STD_NTSC_B  = 3'd6,
        STD_RSVD    = 3'd7
    } tv_std_e;

    typedef enum logic [1:0] {
        VR_EQ_PRE,
        VR_BROAD,
        VR_EQ_POST,
        VR_PICTURE
    } vregion_e;

    typedef struct packed {
        logic [LNW-1:0] lines;
        logic [2:0]     eq_hl;
        logic [2:0]     broad_hl;
        logic [5:0]     hblank_w;
        logic [4:0]     vblank_lines;
        logic [3:0]     vd_lines;
    } std_cfg_t;

    typedef struct packed {
        logic [HCW-1:0] h;
        logic [HLW-1:0] hl;
    } scan_pos_t;

    function automatic std_cfg_t decode_std(input logic [2:0] sel, input logic single_field);
        std_cfg_t c;
        logic     narrow;
        tv_std_e  s;
        s      = tv_std_e'(sel);
        narrow = (s == STD_NTSC_A) || (s == STD_PAL_M) || (s == STD_NTSC_B);
        c.lines        = (narrow ? LNW'(525) : LNW'(625)) - LNW'(single_field);
        c.eq_hl        = narrow ? 3'd6 : 3'd5;
        c.broad_hl     = (s == STD_PAL_M) ? 3'd7 : c.eq_hl;
        c.vd_lines     = narrow ? 4'd6 : 4'd10;
        case (s)
            STD_NTSC_A: begin
                c.hblank_w     = 6'd56;
                c.vblank_lines = 5'd21;
            end
            STD_NTSC_B: begin
                c.hblank_w     = 6'd53;
                c.vblank_lines = 5'd19;
            end
            default: begin
                c.hblank_w     = 6'd60;
                c.vblank_lines = 5'd25;
            end
        endcase
        return c;
    endfunction

    function automatic logic [HCW-1:0] half_pos(input logic [HCW-1:0] h);
        return (h >= H_HALF) ? (h - H_HALF) : h;
    endfunction

endpackage

// File: rtl/mstd_sync_timebase.sv
module mstd_sync_timebase
    import mstd_sync_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           tick,
    input  logic           frame_rst,
    input  logic [HLW-1:0] frame_hl,
    output scan_pos_t      pos
);
    logic half_end;

    assign half_end = (pos.h == H_HALF_LAST) || (pos.h == H_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            pos <= '0;
        end else if (tick) begin
            if (frame_rst) begin
                pos <= '0;
            end else begin
                pos.h <= (pos.h == H_LAST) ? '0 : pos.h + 1'b1;
                if (half_end) begin
                    pos.hl <= (pos.hl >= frame_hl - 1'b1) ? '0 : pos.hl + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/mstd_field_locate.sv
module mstd_field_locate
    import mstd_sync_pkg::*;
(
    input  logic [HLW-1:0] hl,
    input  logic [LNW-1:0] lines,
    output logic [HLW-1:0] rel_hl,
    output logic           second
);
    always_comb begin
        second = (hl >= HLW'(lines));
        rel_hl = second ? (hl - HLW'(lines)) : hl;
    end
endmodule

// File: rtl/mstd_pulse_gen.sv
module mstd_pulse_gen
    import mstd_sync_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           tick,
    input  std_cfg_t       cfg,
    input  logic [HCW-1:0] h,
    input  logic [HLW-1:0] rel_now,
    input  logic [HLW-1:0] rel_lag,
    output logic           csync,
    output logic           cblank,
    output logic           vdrive
);
    logic [HCW-1:0] p;
    logic [HLW-1:0] eq_end, broad_end, post_end, vb_end, vd_end;
    vregion_e       region;
    logic           cs_n, hb_n, vb_n, vd_n;

    always_comb begin
        p         = half_pos(h);
        eq_end    = HLW'(cfg.eq_hl);
        broad_end = eq_end + HLW'(cfg.broad_hl);
        post_end  = broad_end + eq_end;
        vb_end    = HLW'({cfg.vblank_lines, 1'b0});
        vd_end    = HLW'({cfg.vd_lines, 1'b0});

        if (rel_now < eq_end)         region = VR_EQ_PRE;
        else if (rel_now < broad_end) region = VR_BROAD;
        else if (rel_now < post_end)  region = VR_EQ_POST;
        else                          region = VR_PICTURE;

        case (region)
            VR_EQ_PRE, VR_EQ_POST: cs_n = (p < EQ_TICKS);
            VR_BROAD:              cs_n = (p < (H_HALF - SERR_GAP));
            default:               cs_n = (h < SYNC_TICKS);
        endcase

        hb_n = (h > (H_LAST - PORCH_TICKS)) || (h < (HCW'(cfg.hblank_w) - PORCH_TICKS));
        vb_n = (rel_now < vb_end);
        vd_n = (rel_lag < vd_end);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            csync  <= 1'b0;
            cblank <= 1'b0;
            vdrive <= 1'b0;
        end else if (tick) begin
            csync  <= cs_n;
            cblank <= hb_n | vb_n;
            vdrive <= vd_n;
        end
    end
endmodule

// File: rtl/mstd_sync_gen.sv
module mstd_sync_gen
    import mstd_sync_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           tick,
    input  logic           frame_rst,
    input  logic [2:0]     std_sel,
    input  logic           single_field,
    output logic           csync,
    output logic           cblank,
    output logic           vdrive,
    output logic [HCW-1:0] h_pos,
    output logic [LNW-1:0] line_no,
    output logic           field_idx
);
    localparam int NLOC = 2;

    std_cfg_t       cfg;
    scan_pos_t      pos;
    logic [HLW-1:0] frame_hl;
    logic [HLW-1:0] hl_lag;
    logic [HLW-1:0] loc_hl  [NLOC];
    logic [HLW-1:0] loc_rel [NLOC];
    logic           loc_sec [NLOC];

    always_comb begin
        cfg      = decode_std(std_sel, single_field);
        frame_hl = {cfg.lines, 1'b0};
        if (half_pos(pos.h) < VD_LAG)
            hl_lag = (pos.hl == '0) ? frame_hl - 1'b1 : pos.hl - 1'b1;
        else
            hl_lag = pos.hl;
        loc_hl[0] = pos.hl;
        loc_hl[1] = hl_lag;
    end

    mstd_sync_timebase u_tb (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .frame_rst (frame_rst),
        .frame_hl  (frame_hl),
        .pos       (pos)
    );

    for (genvar g = 0; g < NLOC; g++) begin : g_loc
        mstd_field_locate u_loc (
            .hl     (loc_hl[g]),
            .lines  (cfg.lines),
            .rel_hl (loc_rel[g]),
            .second (loc_sec[g])
        );
    end

    mstd_pulse_gen u_pg (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .cfg     (cfg),
        .h       (pos.h),
        .rel_now (loc_rel[0]),
        .rel_lag (loc_rel[1]),
        .csync   (csync),
        .cblank  (cblank),
        .vdrive  (vdrive)
    );

    assign h_pos     = pos.h;
    assign line_no   = pos.hl[HLW-1:1] + 1'b1;
    assign field_idx = loc_sec[0];
endmodule

// File: rtl/mstd_sync_gen_chk.sv
module mstd_sync_gen_chk
    import mstd_sync_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input logic           tick,
    input logic           frame_rst,
    input logic           csync,
    input logic           cblank,
    input logic           vdrive,
    input logic [HCW-1:0] h_pos,
    input logic [LNW-1:0] line_no,
    input logic           field_idx
);
    AST_HPOS_RANGE: assert property (@(posedge clk) disable iff (rst)
        h_pos <= H_LAST); // R1

    AST_HPOS_STEP: assert property (@(posedge clk) disable iff (rst)
        tick && !frame_rst && (h_pos != H_LAST) |=> h_pos == $past(h_pos) + 1'b1); // R1

    AST_HPOS_WRAP: assert property (@(posedge clk) disable iff (rst)
        tick && !frame_rst && (h_pos == H_LAST) |=> h_pos == '0); // R1

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(h_pos) && $stable(line_no) && $stable(csync)
                  && $stable(cblank) && $stable(vdrive)); // R1

    AST_FRAME_RESTART: assert property (@(posedge clk) disable iff (rst)
        tick && frame_rst |=> h_pos == '0 && line_no == LNW'(1) && !field_idx); // R10

    AST_SYNC_BLANKED: assert property (@(posedge clk) disable iff (rst)
        csync |-> cblank); // R7

    AST_VD_BLANKED: assert property (@(posedge clk) disable iff (rst)
        vdrive |-> cblank); // R9

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> !csync && !cblank && !vdrive && h_pos == '0 && line_no == LNW'(1)); // R11
endmodule

bind mstd_sync_gen mstd_sync_gen_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .frame_rst (frame_rst),
    .csync     (csync),
    .cblank    (cblank),
    .vdrive    (vdrive),
    .h_pos     (h_pos),
    .line_no   (line_no),
    .field_idx (field_idx)
);

// File: tb/mstd_sync_gen_test.sv
module mstd_sync_gen_test;
    localparam int CLK_PERIOD = 10;
    localparam int LT         = 320;
    localparam int WATCHDOG   = 195000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       frame_rst = 1'b0;
    logic [2:0] std_sel = 3'd0;
    logic       single_field = 1'b0;
    logic       csync, cblank, vdrive, field_idx;
    logic [8:0] h_pos;
    logic [9:0] line_no;

    int n_cmp = 0;
    int n_bad = 0;

    int    m_h = 0, m_hl = 0;
    bit    e_cs = 0, e_cb = 0, e_vd = 0;
    string cs_tag = "R4", cb_tag = "R7";

    mstd_sync_gen uut (
        .clk(clk), .rst(rst), .tick(tick), .frame_rst(frame_rst),
        .std_sel(std_sel), .single_field(single_field),
        .csync(csync), .cblank(cblank), .vdrive(vdrive),
        .h_pos(h_pos), .line_no(line_no), .field_idx(field_idx)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d (line %0d h %0d std %0d sf %0d)",
                     tag, what, act, exp, m_hl/2 + 1, m_h, std_sel, single_field);
        end
    endtask

    function automatic int frame_lines();
        bit n525 = (std_sel == 3'd2) || (std_sel == 3'd3) || (std_sel == 3'd6);
        return (n525 ? 525 : 625) - int'(single_field);
    endfunction

    // Expected outputs for the current position, then advance the position
    task automatic model_tick();
        bit n525 = (std_sel == 3'd2) || (std_sel == 3'd3) || (std_sel == 3'd6);
        int L    = frame_lines();
        int E    = n525 ? 6 : 5;
        int S    = (std_sel == 3'd3) ? 7 : E;
        int W    = (std_sel == 3'd2) ? 56 : (std_sel == 3'd6) ? 53 : 60;
        int V    = (std_sel == 3'd2) ? 21 : (std_sel == 3'd6) ? 19 : 25;
        int VDL  = n525 ? 6 : 10;
        int p    = m_h % (LT/2);
        int r    = (m_hl >= L) ? m_hl - L : m_hl;
        int hl8  = (p < 8) ? ((m_hl == 0) ? 2*L - 1 : m_hl - 1) : m_hl;
        int r8   = (hl8 >= L) ? hl8 - L : hl8;
        bit hb;
        if (r < E || (r >= E + S && r < 2*E + S)) begin
            e_cs = (p < 12); cs_tag = "R5";
        end else if (r < E + S) begin
            e_cs = (p < LT/2 - 24); cs_tag = "R6";
        end else begin
            e_cs = (m_h < 24); cs_tag = "R4";
        end
        hb     = (m_h >= LT - 8) || (m_h < W - 8);
        e_cb   = hb || (r < 2*V);
        cb_tag = (r < 2*V) ? "R8" : "R7";
        e_vd   = (r8 < 2*VDL);
        if (frame_rst) begin
            m_h = 0; m_hl = 0;
        end else begin
            if (m_h == LT/2 - 1 || m_h == LT - 1)
                m_hl = (m_hl >= 2*L - 1) ? 0 : m_hl + 1;
            m_h = (m_h == LT - 1) ? 0 : m_h + 1;
        end
    endtask

    task automatic step();
        @(posedge clk);
        if (tick) model_tick();
        @(negedge clk);
        chk(csync == e_cs,  cs_tag, "csync",  csync,  e_cs);
        chk(cblank == e_cb, cb_tag, "cblank", cblank, e_cb);
        chk(vdrive == e_vd, "R9", "vdrive", vdrive, e_vd);
        chk(h_pos == 9'(m_h), "R1", "h_pos", h_pos, m_h);
        chk(line_no == 10'(m_hl/2 + 1), "R2", "line_no", line_no, m_hl/2 + 1);
        chk(field_idx == (m_hl >= frame_lines()), "R3", "field_idx", field_idx,
            int'(m_hl >= frame_lines()));
    endtask

    task automatic run_ticks(input int n);
        tick = 1'b1;
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic restart_frame();
        frame_rst = 1'b1;
        tick      = 1'b1;
        step();
        chk(h_pos == 9'd0 && line_no == 10'd1 && field_idx == 1'b0, "R10",
            "restart position", int'(h_pos) + int'(line_no) * 1000, 1000);
        frame_rst = 1'b0;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: quiet outputs and home position while reset is held
        chk(!csync && !cblank && !vdrive, "R11", "pulses in reset",
            int'({csync, cblank, vdrive}), 0);
        chk(h_pos == 9'd0 && line_no == 10'd1 && !field_idx, "R11", "position in reset",
            int'(h_pos) + int'(line_no) * 1000, 1000);
        rst = 1'b0;

        // R1: idle cycles change nothing
        tick = 1'b0;
        for (int i = 0; i < 5; i++) step();
        run_ticks(700);
        tick = 1'b0;
        for (int i = 0; i < 5; i++) step();

        // Start of field 1 for every standard code, interlaced
        for (int code = 0; code < 8; code++) begin
            std_sel      = 3'(code);
            single_field = 1'b0;
            restart_frame();
            run_ticks(26 * LT);
        end

        // Interlaced 525-line frame through the mid-line start of field 2 (R3)
        std_sel = 3'd2;
        restart_frame();
        run_ticks(288 * LT);

        // Non-interlaced 624-line frame: field 2 starts on a line boundary
        std_sel      = 3'd5;
        single_field = 1'b1;
        run_ticks(52 * LT);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule